// File: doc/BRIEF.md
# Seven-Slot Pixel Serializer for Flat-Panel Differential Links

The block turns one parallel pixel per pixel period into serial bits. Each pixel is 8-bit red, green and blue plus horizontal sync, vertical sync and data enable. The bits go out on up to four data lanes, with seven bit slots per lane in each pixel period. A clock lane carries a matching seven-slot pattern.

A fast bit-clock enable, running at seven times the pixel rate, steps a slot counter. When the counter passes from slot 6 back to slot 0, the block captures the pixel, the mapping selector and the mirror control into a holding register. A mode change therefore only takes effect on a whole-pixel boundary.

Three mappings can be chosen at run time:
- an 18-bit layout on three lanes;
- two different 24-bit layouts on four lanes.

The mirror control sends every data lane in slot order 6 down to 0. The clock lane is not affected by mirror.

Top module: `lvds_slot_serializer`

## Requirements
- R1: A slot counter steps 0,1,..,6,0 on each cycle with `bit_en` high. Outputs hold their value on cycles with `bit_en` low.
- R2: After synchronous reset the slot is 0, and all data lanes and the clock lane stay 0 until the first load. The first load happens on the seventh `bit_en` pulse, the one taken at slot 6.
- R3: With `map_sel`=0 (18-bit), colour bits 7..2 of each channel stand for 6-bit values c5..c0. Lane 0 sends, for slots 0..6: G0,R5,R4,R3,R2,R1,R0. Lane 1 sends B1,B0,G5,G4,G3,G2,G1. Lane 2 sends C2,C1,C0,B5,B4,B3,B2. Lane 3 is held at 0.
- R4: With `map_sel`=1, using 8-bit colour, the slots 0..6 carry the following. Lane 0: G2,R7,R6,R5,R4,R3,R2. Lane 1: B3,B2,G7,G6,G5,G4,G3. Lane 2: C2,C1,C0,B7,B6,B5,B4. Lane 3: C3,B1,B0,G1,G0,R1,R0.
- R5: With `map_sel`=2, lanes 0..2 use the R3 slot layout but take colour bits 5..0 as c5..c0. Lane 3, for slots 0..6, carries C3,B7,B6,G7,G6,R7,R6.
- R6: `map_sel`=3 behaves exactly as `map_sel`=0.
- R7: The control bits are fixed: C0 is hsync, C1 is vsync, C2 is data enable, and C3 is constant 0.
- R8: When the captured mirror bit is 1, each data lane sends slot 6 first and slot 0 last. The clock lane is unchanged by mirror.
- R9: Once loaded, the clock lane sends 1,1,0,0,0,1,1 for slots 0..6 in every pixel period.
- R10: The pixel, mapping and mirror inputs are sampled only at the load point. Any change at other times has no effect on the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-slot enable, 7 per pixel period |
| pix_r | input | 8 | Red channel |
| pix_g | input | 8 | Green channel |
| pix_b | input | 8 | Blue channel |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| map_sel | input | 2 | Slot mapping select (0/3: 18-bit, 1 and 2: 24-bit variants) |
| mirror | input | 1 | Reverse slot order on data lanes |
| lane_out | output | 4 | Serial data lanes, bit i is lane i |
| clk_lane | output | 1 | Clock-lane pattern |

## Verification
A slot counter that is out of step shifts every lane and the clock-lane pattern. This is visible on the very next slot as a clock-lane 1 where a 0 is expected.

A holding register that latches early, or at the wrong point, lets mid-period input changes leak onto the lanes within the same pixel period. The mirror or mode bit is also captured from the wrong pixel. A stale or wrongly set valid flag shows as nonzero lanes during the first seven slots after reset, or as zeros after the first load.

The bench compares every slot of every lane, including idle cycles between enables. Any such fault is therefore caught within one pixel period.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

   typedef enum logic [1:0] {
      MAP_N18  = 2'd0,
      MAP_W24A = 2'd1,
      MAP_W24B = 2'd2,
      MAP_ALT  = 2'd3
   } map_e;

   typedef struct packed {
      logic [7:0] red;
      logic [7:0] grn;
      logic [7:0] blu;
      logic       hs;
      logic       vs;
      logic       de;
   } pix_t;

endpackage

// File: rtl/lvds_slot_counter.sv
module lvds_slot_counter #(
   parameter int NUM_SLOTS = 7,
   localparam int SW = $clog2(NUM_SLOTS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bit_en,
   output logic [SW-1:0] slot,
   output logic          wrap
);
   localparam logic [SW-1:0] LAST = SW'(NUM_SLOTS - 1);

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("NUM_SLOTS must be at least 2");
   end

   assign wrap = bit_en && (slot == LAST);

   always_ff @(posedge clk) begin
      if (rst)          slot <= '0;
      else if (wrap)    slot <= '0;
      else if (bit_en)  slot <= slot + 1'b1;
   end

   a_r1_wraps: assert property (@(posedge clk) disable iff (rst)
      (bit_en && slot == LAST) |=> (slot == '0));
   a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> $stable(slot));
   a_r1_in_range: assert property (@(posedge clk) disable iff (rst)
      slot <= LAST);
endmodule

// File: rtl/lvds_pixel_hold.sv
module lvds_pixel_hold
   import lvds_ser_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  pix_t pix_in,
   input  map_e mode_in,
   input  logic mirror_in,
   output pix_t pix_q,
   output map_e mode_q,
   output logic mirror_q,
   output logic valid_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         pix_q    <= '0;
         mode_q   <= MAP_N18;
         mirror_q <= 1'b0;
         valid_q  <= 1'b0;
      end else if (load) begin
         pix_q    <= pix_in;
         mode_q   <= mode_in;
         mirror_q <= mirror_in;
         valid_q  <= 1'b1;
      end
   end

   a_r10_hold_pix: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(pix_q) && $stable(mode_q) && $stable(mirror_q)));
   a_r2_valid_sticky: assert property (@(posedge clk) disable iff (rst)
      valid_q |=> valid_q);
endmodule

// File: rtl/lvds_lane_map.sv
module lvds_lane_map
   import lvds_ser_pkg::*;
#(
   parameter int NUM_LANES = 4,
   parameter int NUM_SLOTS = 7
) (
   input  pix_t pix,
   input  map_e mode,
   output logic [NUM_LANES-1:0][NUM_SLOTS-1:0] words
);
   typedef logic [2:0][6:0] trio_t;

   if (NUM_LANES != 4) begin : g_bad_lanes
      $error("lane map is defined for four data lanes");
   end
   if (NUM_SLOTS != 7) begin : g_bad_slot_cnt
      $error("lane map is defined for seven slots");
   end

   // Shared 3-lane layout on 6-bit colour values; vector bit index = slot.
   function automatic trio_t base3(input logic [5:0] r6, input logic [5:0] g6,
                                   input logic [5:0] b6, input logic hs,
                                   input logic vs, input logic de);
      trio_t t;
      t[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
      t[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
      t[2] = {b6[2], b6[3], b6[4], b6[5], hs, vs, de};
      return t;
   endfunction

   trio_t hi_trio, lo_trio;
   logic [6:0] lane3_a, lane3_b;

   assign hi_trio = base3(pix.red[7:2], pix.grn[7:2], pix.blu[7:2], pix.hs, pix.vs, pix.de);
   assign lo_trio = base3(pix.red[5:0], pix.grn[5:0], pix.blu[5:0], pix.hs, pix.vs, pix.de);
   assign lane3_a = {pix.red[0], pix.red[1], pix.grn[0], pix.grn[1],
                     pix.blu[0], pix.blu[1], 1'b0};
   assign lane3_b = {pix.red[6], pix.red[7], pix.grn[6], pix.grn[7],
                     pix.blu[6], pix.blu[7], 1'b0};

   always_comb begin
      case (mode)
         MAP_W24A: words = {lane3_a, hi_trio};
         MAP_W24B: words = {lane3_b, lo_trio};
         default:  words = {7'd0, hi_trio};
      endcase
   end
endmodule

// File: rtl/lvds_slot_serializer.sv
module lvds_slot_serializer
   import lvds_ser_pkg::*;
#(
   parameter int         COLOR_W     = 8,
   parameter int         NUM_LANES   = 4,
   parameter int         NUM_SLOTS   = 7,
   parameter logic [6:0] CLK_PATTERN = 7'b1100011,
   localparam int        SW          = $clog2(NUM_SLOTS)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bit_en,
   input  logic [COLOR_W-1:0] pix_r,
   input  logic [COLOR_W-1:0] pix_g,
   input  logic [COLOR_W-1:0] pix_b,
   input  logic               pix_hs,
   input  logic               pix_vs,
   input  logic               pix_de,
   input  logic [1:0]         map_sel,
   input  logic               mirror,
   output logic [NUM_LANES-1:0] lane_out,
   output logic               clk_lane
);
   localparam logic [SW-1:0] LAST = SW'(NUM_SLOTS - 1);

   if (COLOR_W != 8) begin : g_bad_color
      $error("COLOR_W must be 8");
   end

   logic [SW-1:0] slot, eff_slot;
   logic          load;
   pix_t          pix_d, pix_q;
   map_e          mode_q;
   logic          mirror_q, valid_q;
   logic [NUM_LANES-1:0][NUM_SLOTS-1:0] words;

   assign pix_d = '{red: pix_r, grn: pix_g, blu: pix_b,
                    hs: pix_hs, vs: pix_vs, de: pix_de};

   lvds_slot_counter #(.NUM_SLOTS(NUM_SLOTS)) u_cnt (
      .clk(clk), .rst(rst), .bit_en(bit_en), .slot(slot), .wrap(load));

   lvds_pixel_hold u_hold (
      .clk(clk), .rst(rst), .load(load), .pix_in(pix_d),
      .mode_in(map_e'(map_sel)), .mirror_in(mirror),
      .pix_q(pix_q), .mode_q(mode_q), .mirror_q(mirror_q), .valid_q(valid_q));

   lvds_lane_map #(.NUM_LANES(NUM_LANES), .NUM_SLOTS(NUM_SLOTS)) u_map (
      .pix(pix_q), .mode(mode_q), .words(words));

   assign eff_slot = mirror_q ? (LAST - slot) : slot;

   for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
      assign lane_out[ln] = valid_q & words[ln][eff_slot];
   end

   assign clk_lane = valid_q & CLK_PATTERN[slot];

   a_r2_quiet_before_load: assert property (@(posedge clk) disable iff (rst)
      !valid_q |-> (lane_out == '0 && !clk_lane));
   a_r9_clk_high_slot0: assert property (@(posedge clk) disable iff (rst)
      (valid_q && slot == '0) |-> clk_lane);
   a_r9_clk_low_mid: assert property (@(posedge clk) disable iff (rst)
      (valid_q && slot == SW'(3)) |-> !clk_lane);
   a_r3_lane3_idle: assert property (@(posedge clk) disable iff (rst)
      (valid_q && (mode_q == MAP_N18 || mode_q == MAP_ALT)) |-> !lane_out[3]);
   a_r7_ctl3_zero: assert property (@(posedge clk) disable iff (rst)
      (valid_q && !mirror_q && slot == '0) |-> !lane_out[3]);
endmodule

// File: tb/lvds_slot_serializer_test.sv
module lvds_slot_serializer_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_en = 1'b0;
   logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
   logic pix_hs = 0, pix_vs = 0, pix_de = 0;
   logic [1:0] map_sel = '0;
   logic mirror = 0;
   logic [3:0] lane_out;
   logic clk_lane;

   int total = 0;
   int bad = 0;
   bit mon_on = 0;
   bit done = 0;
   logic [4:0] exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   lvds_slot_serializer uut (
      .clk(clk), .rst(rst), .bit_en(bit_en), .pix_r(pix_r), .pix_g(pix_g),
      .pix_b(pix_b), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
      .map_sel(map_sel), .mirror(mirror), .lane_out(lane_out), .clk_lane(clk_lane));

   // Expected {clk_lane, lane3..lane0} for one slot, built from the requirements.
   function automatic logic [4:0] expect_slot(input logic [7:0] r, input logic [7:0] g,
         input logic [7:0] b, input logic hs, input logic vs, input logic de,
         input logic [1:0] md, input logic mir, input int s);
      logic [6:0] v0, v1, v2, v3;
      logic [6:0] ck;
      int e;
      ck = 7'b1100011;                                  // R9
      if (md == 2'd1) begin                             // R4
         v0 = {r[2], r[3], r[4], r[5], r[6], r[7], g[2]};
         v1 = {g[3], g[4], g[5], g[6], g[7], b[2], b[3]};
         v2 = {b[4], b[5], b[6], b[7], hs, vs, de};     // R7
         v3 = {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0};
      end else if (md == 2'd2) begin                    // R5
         v0 = {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
         v1 = {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
         v2 = {b[2], b[3], b[4], b[5], hs, vs, de};
         v3 = {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0};
      end else begin                                    // R3, R6
         v0 = {r[2], r[3], r[4], r[5], r[6], r[7], g[2]};
         v1 = {g[3], g[4], g[5], g[6], g[7], b[2], b[3]};
         v2 = {b[4], b[5], b[6], b[7], hs, vs, de};
         v3 = 7'd0;
      end
      e = mir ? 6 - s : s;                              // R8
      return {ck[s], v3[e], v2[e], v1[e], v0[e]};
   endfunction

   task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Monitor: current slot is the queue head; popped when bit_en is consumed.
   always @(negedge clk) begin
      if (mon_on && !rst && exp_q.size() > 0) begin
         check(tag_q[0], {clk_lane, lane_out}, exp_q[0]);
         if (bit_en) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   task automatic push_zero_period(input string tag);
      for (int s = 0; s < 7; s++) begin
         exp_q.push_back(5'd0);
         tag_q.push_back(tag);
      end
   endtask

   // Driver: pushes expectations for this pixel (shown next period), runs 7 pulses.
   task automatic send(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
         input logic hs, input logic vs, input logic de, input logic [1:0] md,
         input logic mir, input bit scramble, input bit gaps, input string tag);
      for (int s = 0; s < 7; s++) begin
         exp_q.push_back(expect_slot(r, g, b, hs, vs, de, md, mir, s));
         tag_q.push_back(tag);
      end
      for (int k = 0; k < 7; k++) begin
         @(posedge clk); #1;
         if (scramble && k < 6) begin                   // R10: ignored changes
            pix_r = ~r ^ 8'(k); pix_g = ~g; pix_b = b ^ 8'h5A;
            pix_hs = ~hs; pix_vs = ~vs; pix_de = ~de;
            map_sel = md + 2'd1; mirror = ~mir;
         end else begin
            pix_r = r; pix_g = g; pix_b = b;
            pix_hs = hs; pix_vs = vs; pix_de = de;
            map_sel = md; mirror = mir;
         end
         bit_en = 1'b1;
         if (gaps) begin                                // R1: idle cycles
            @(posedge clk); #1;
            bit_en = 1'b0;
            @(posedge clk); #1;
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check("R2 reset state", {clk_lane, lane_out}, 5'd0);
      push_zero_period("R2 quiet before load");
      mon_on = 1;
      send(8'hA5, 8'h3C, 8'hF0, 1, 0, 1, 2'd0, 0, 0, 0, "R3 18-bit");
      send(8'h5A, 8'hC3, 8'h0F, 0, 1, 0, 2'd0, 0, 0, 1, "R3 18-bit gaps R1");
      send(8'hE7, 8'h18, 8'h99, 1, 1, 1, 2'd1, 0, 0, 0, "R4 24-bit A R7");
      send(8'h81, 8'h7E, 8'h42, 0, 0, 1, 2'd1, 0, 1, 0, "R4 24-bit A R10");
      send(8'h3C, 8'hA5, 8'hC6, 1, 0, 0, 2'd2, 0, 0, 0, "R5 24-bit B");
      send(8'hC1, 8'h83, 8'h6D, 0, 1, 1, 2'd2, 1, 0, 1, "R5 mirror R8");
      send(8'h9B, 8'h64, 8'hD2, 1, 0, 1, 2'd3, 0, 0, 0, "R6 alias");
      send(8'hFF, 8'h00, 8'hFF, 1, 1, 0, 2'd0, 1, 1, 0, "R8 mirror R10");
      send(8'h12, 8'hEF, 8'h77, 0, 0, 0, 2'd1, 1, 0, 0, "R8 mirror 24A R9");
      send(8'h00, 8'h00, 8'h00, 0, 0, 0, 2'd0, 0, 0, 0, "R9 clock only");
      send(8'h00, 8'h00, 8'h00, 0, 0, 0, 2'd0, 0, 0, 0, "R9 flush");
      // Synchronous reset mid-stream returns all lanes to 0.
      @(posedge clk); #1;
      bit_en = 1'b0; rst = 1'b1;
      @(posedge clk); #1;
      exp_q.delete(); tag_q.delete();
      rst = 1'b0;
      @(negedge clk);
      check("R2 after mid reset", {clk_lane, lane_out}, 5'd0);
      push_zero_period("R2 restart quiet");
      send(8'h6B, 8'hB6, 8'h2D, 1, 0, 1, 2'd2, 0, 1, 1, "R2 restart R5");
      send(8'h00, 8'h00, 8'h00, 0, 0, 0, 2'd0, 0, 0, 0, "R2 restart flush");
      @(posedge clk); #1 bit_en = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule